// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a compact processor that retires one instruction on every rising clock edge. It holds a general register file of thirty-two 32-bit entries and an instruction store and a data store, both internal word arrays. It decodes three fixed-width instruction layouts: register-register, register-immediate and long jump. The supported operations are add, subtract, the bitwise and/or/nor, logical shifts, signed set-on-less-than, word loads and stores, two compare-and-branch forms, a direct jump, a jump that saves a return address, and a jump through a register. There are no delay slots, and overflow does not trap.

The surrounding logic holds `rst_n` low and fills both stores through their write ports. It then releases reset and watches the `halt` flag, which rises when the core fetches the all-ones word. Any register can be read at any time through a combinational debug read port. Reset is applied asynchronously and released through a two-stage synchroniser, so execution begins a fixed number of edges after release.

Top module: `rcore_top`

## Requirements
- R1: The register file has 32 entries of 32 bits, selected by a 5-bit index. Index 0 always reads as zero, and a write that targets index 0 changes nothing.
- R2: Instruction bits are split as op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. With op = 0, funct 32 is add, 34 is sub, 36 is and, 37 is or, 39 is nor and 42 is slt, each writing rd from rs and rt. For example, 0x02324020 adds r17 and r18 into r8.
- R3: The immediate forms use opcodes addi 8, slti 10, andi 12 and ori 13. Each writes rt from rs and the low 16 bits. addi and slti sign-extend the immediate; andi and ori zero-extend it.
- R4: slt and slti compare as signed two's-complement numbers. They write 1 when the first operand is smaller and 0 otherwise.
- R5: sll (funct 0) and srl (funct 2) shift rt by shamt into rd and fill vacated bits with zeros. nor writes the inverse of (rs OR rt).
- R6: lw (opcode 35) loads rt and sw (opcode 43) stores rt. The byte address is rs plus the sign-extended immediate, and address bits [7:2] (with the default depth) select the data word.
- R7: beq (opcode 4) and bne (opcode 5) compare rs with rt. When taken, the next PC is PC+4 plus the sign-extended immediate times 4; otherwise it is PC+4.
- R8: j (opcode 2) and jal (opcode 3) go to {PC+4 bits [31:28], 26-bit field, 2'b00}. jal also writes PC+4 into register 31.
- R9: jr (op 0, funct 8) loads the PC from rs and writes no register.
- R10: Fetching 0xFFFFFFFF sets `halt` at the edge where that word would retire, with no register or memory change. Afterwards `halt` stays high, the PC holds and no state changes until reset.
- R11: While `rst_n` is low, all registers read zero and `halt` is low. The first instruction, taken from word 0, retires on the third rising edge after `rst_n` goes high.
- R12: Arithmetic overflow is ignored: add, sub and addi wrap modulo 2^32.
- R13: Exactly one instruction retires per clock edge. Every opcode other than a branch or jump advances the PC by 4. Opcodes not listed above write nothing and advance the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| imem_we | input | 1 | Write strobe for the instruction store |
| imem_addr | input | IAW | Word index into the instruction store |
| imem_wdata | input | 32 | Instruction word to write |
| dmem_we | input | 1 | Write strobe for the data store (takes priority over core stores) |
| dmem_addr | input | DAW | Word index into the data store |
| dmem_wdata | input | 32 | Data word to write |
| dbg_sel | input | 5 | Register index for the debug read port |
| dbg_data | output | 32 | Contents of the selected register |
| halt | output | 1 | High once the halt word has been fetched |

## Verification
The bench uses the default depths of 64 instruction words and 64 data words. This leaves room for a straight-line arithmetic section, a forward jump-and-link to a subroutine at word 40, a return through a register, and a backward counting loop. It also holds a stored word that can be reread from a preloaded data location. A behavioural instruction-set model in the bench steps alongside the core. After each edge, the bench compares the register just written and the halt flag. A second, single-word program shows that reset clears the registers and that a halt word at address 0 stops the core at once.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  localparam logic [XLEN-1:0] HALT_WORD = '1;
  localparam logic [4:0]      LINK_REG  = 5'd31;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_e;

  typedef struct packed {
    logic    wr_en;
    dst_e    dst;
    logic    use_imm;
    logic    zext;
    alu_op_e alu;
    logic    ld;
    logic    st;
    logic    br_eq;
    logic    br_ne;
    logic    jmp;
    logic    jreg;
    logic    link;
    logic    halt;
  } ctrl_t;

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);

  logic [5:0] op;
  logic [5:0] fn;

  assign op = instr[31:26];
  assign fn = instr[5:0];

  always_comb begin
    ctrl = '0;
    ctrl.dst = DST_RT;
    ctrl.alu = ALU_ADD;
    if (instr == HALT_WORD) begin
      ctrl.halt = 1'b1;
    end else begin
      unique case (op)
        OP_RTYPE: begin
          ctrl.dst   = DST_RD;
          ctrl.wr_en = 1'b1;
          unique case (fn)
            FN_ADD:  ctrl.alu = ALU_ADD;
            FN_SUB:  ctrl.alu = ALU_SUB;
            FN_AND:  ctrl.alu = ALU_AND;
            FN_OR:   ctrl.alu = ALU_OR;
            FN_NOR:  ctrl.alu = ALU_NOR;
            FN_SLT:  ctrl.alu = ALU_SLT;
            FN_SLL:  ctrl.alu = ALU_SLL;
            FN_SRL:  ctrl.alu = ALU_SRL;
            FN_JR: begin
              ctrl.wr_en = 1'b0;
              ctrl.jreg  = 1'b1;
            end
            default: ctrl.wr_en = 1'b0;
          endcase
        end
        OP_ADDI: begin
          ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu = ALU_ADD;
        end
        OP_SLTI: begin
          ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu = ALU_SLT;
        end
        OP_ANDI: begin
          ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.zext = 1'b1;
          ctrl.alu = ALU_AND;
        end
        OP_ORI: begin
          ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.zext = 1'b1;
          ctrl.alu = ALU_OR;
        end
        OP_LW: begin
          ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.ld = 1'b1;
        end
        OP_SW: begin
          ctrl.use_imm = 1'b1; ctrl.st = 1'b1;
        end
        OP_BEQ: begin
          ctrl.br_eq = 1'b1; ctrl.alu = ALU_SUB;
        end
        OP_BNE: begin
          ctrl.br_ne = 1'b1; ctrl.alu = ALU_SUB;
        end
        OP_J:   ctrl.jmp = 1'b1;
        OP_JAL: begin
          ctrl.jmp = 1'b1; ctrl.link = 1'b1; ctrl.wr_en = 1'b1;
          ctrl.dst = DST_LINK;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [4:0]      shamt,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: y = b << shamt;
      ALU_SRL: y = b >> shamt;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [RAW-1:0] ra1,
  output logic [W-1:0]   rd1,
  input  logic [RAW-1:0] ra2,
  output logic [W-1:0]   rd2,
  input  logic [RAW-1:0] ra3,
  output logic [W-1:0]   rd3
);

  logic [W-1:0] rf [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign rf[i] = '0;
    end else begin : g_reg
      logic         en;
      logic [W-1:0] q;
      logic [W-1:0] d;
      assign en = we && (waddr == RAW'(i));
      always_comb d = en ? wdata : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign rf[i] = q;
    end
  end

  assign rd1 = rf[ra1];
  assign rd2 = rf[ra2];
  assign rd3 = rf[ra3];

endmodule

// File: rtl/rcore_wordmem.sv
module rcore_wordmem #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int  IMEM_WORDS = 64,
  parameter int  DMEM_WORDS = 64,
  parameter int  NREGS      = 32,
  localparam int IAW        = $clog2(IMEM_WORDS),
  localparam int DAW        = $clog2(DMEM_WORDS),
  localparam int RAW        = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imem_we,
  input  logic [IAW-1:0]  imem_addr,
  input  logic [XLEN-1:0] imem_wdata,
  input  logic            dmem_we,
  input  logic [DAW-1:0]  dmem_addr,
  input  logic [XLEN-1:0] dmem_wdata,
  input  logic [RAW-1:0]  dbg_sel,
  output logic [XLEN-1:0] dbg_data,
  output logic            halt
);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // architectural state
  logic [XLEN-1:0] pc_q, pc_d;
  logic            halt_q, halt_d;
  logic [XLEN-1:0] instr;
  ctrl_t           ctrl;
  logic            step_en, commit;

  rcore_wordmem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (imem_addr),
    .wdata (imem_wdata),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  rcore_decode u_dec (.instr(instr), .ctrl(ctrl));

  assign step_en = !halt_q;
  assign commit  = step_en && !ctrl.halt;

  // operands
  logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, wr_idx;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wr_val;
  logic [XLEN-1:0] pc_plus4, br_tgt, j_tgt, npc, ld_val;
  logic            alu_zero, taken, rf_we;

  assign rs_idx  = instr[25:21];
  assign rt_idx  = instr[20:16];
  assign rd_idx  = instr[15:11];
  assign imm_ext = ctrl.zext ? {16'h0000, instr[15:0]}
                             : {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  rcore_alu u_alu (
    .op    (ctrl.alu),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (instr[10:6]),
    .y     (alu_y),
    .zero  (alu_zero)
  );

  // data store: external load port wins over core stores
  logic            dm_we;
  logic [DAW-1:0]  dm_waddr;
  logic [XLEN-1:0] dm_wdata;

  assign dm_we    = dmem_we || (commit && ctrl.st);
  assign dm_waddr = dmem_we ? dmem_addr  : alu_y[DAW+1:2];
  assign dm_wdata = dmem_we ? dmem_wdata : rt_val;

  rcore_wordmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DAW+1:2]),
    .rdata (ld_val)
  );

  // writeback
  always_comb begin
    unique case (ctrl.dst)
      DST_RD:   wr_idx = rd_idx;
      DST_LINK: wr_idx = LINK_REG;
      default:  wr_idx = rt_idx;
    endcase
  end

  assign wr_val = ctrl.link ? pc_plus4 : (ctrl.ld ? ld_val : alu_y);
  assign rf_we  = commit && ctrl.wr_en;

  rcore_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (rf_we),
    .waddr (wr_idx),
    .wdata (wr_val),
    .ra1   (rs_idx),
    .rd1   (rs_val),
    .ra2   (rt_idx),
    .rd2   (rt_val),
    .ra3   (dbg_sel),
    .rd3   (dbg_data)
  );

  // next PC
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign taken    = (ctrl.br_eq && alu_zero) || (ctrl.br_ne && !alu_zero);

  always_comb begin
    if (ctrl.jreg)     npc = rs_val;
    else if (ctrl.jmp) npc = j_tgt;
    else if (taken)    npc = br_tgt;
    else               npc = pc_plus4;
  end

  always_comb begin
    pc_d   = commit ? npc : pc_q;
    halt_d = halt_q || (step_en && ctrl.halt);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      halt_q <= halt_d;
    end
  end

  assign halt = halt_q;

endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halt,
  input logic [31:0] pc_q,
  input logic [31:0] instr,
  input logic [4:0]  dbg_sel,
  input logic [31:0] dbg_data
);

  logic [31:0] seq_pc;
  logic [31:0] jump_pc;
  logic        plain_op;

  assign seq_pc   = pc_q + 32'd4;
  assign jump_pc  = {seq_pc[31:28], instr[25:0], 2'b00};
  assign plain_op = (instr != 32'hFFFF_FFFF) &&
                    (instr[31:26] inside {6'd8, 6'd10, 6'd12, 6'd13, 6'd35, 6'd43});

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt); // R10

  AST_HALT_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(pc_q)); // R10

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && instr == 32'hFFFF_FFFF) |=> halt); // R10

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_sel == 5'd0) |-> (dbg_data == 32'd0)); // R1

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && plain_op) |=> (pc_q == $past(seq_pc))); // R13

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && instr != 32'hFFFF_FFFF && instr[31:26] inside {6'd2, 6'd3})
      |=> (pc_q == $past(jump_pc))); // R8

endmodule

bind rcore_top rcore_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .halt     (halt),
  .pc_q     (pc_q),
  .instr    (instr),
  .dbg_sel  (dbg_sel),
  .dbg_data (dbg_data)
);

// File: tb/rcore_top_tb.sv
`timescale 1ns/10ps
module rcore_top_tb;

  localparam int IW  = 64;
  localparam int DW  = 64;
  localparam int IAB = $clog2(IW);
  localparam int DAB = $clog2(DW);
  localparam logic [31:0] HW = 32'hFFFF_FFFF;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           imem_we = 1'b0;
  logic [IAB-1:0] imem_addr = '0;
  logic [31:0]    imem_wdata = '0;
  logic           dmem_we = 1'b0;
  logic [DAB-1:0] dmem_addr = '0;
  logic [31:0]    dmem_wdata = '0;
  logic [4:0]     dbg_sel = '0;
  logic [31:0]    dbg_data;
  logic           halt;

  always #4 clk = ~clk;   // 125 MHz

  rcore_top #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .halt(halt)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [31:0] mreg [32];
  logic [31:0] mdm  [DW];
  logic [31:0] mim  [IW];
  logic [31:0] mpc;
  bit          mhalt;
  int          mlast;
  string       mtag;
  logic [31:0] prog [IW];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
      input logic [4:0] rt, input logic [4:0] rd, input logic [4:0] sh);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
      input logic [4:0] rt, input int imm);
    logic [31:0] v;
    v = imm;
    return {op, rs, rt, v[15:0]};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input int tgt);
    logic [31:0] v;
    v = tgt;
    return {op, v[25:0]};
  endfunction

  task automatic wr(input int idx, input logic [31:0] val, input string tag);
    if (idx != 0) mreg[idx] = val;
    mlast = idx;
    mtag  = tag;
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, se, ze, pc4, npc, addr;
    logic [5:0]  op, fn;
    int          rs, rt, rd, sh;
    mlast = -1;
    mtag  = "R13";
    if (mhalt) begin
      mtag = "R10";
      return;
    end
    ins = mim[mpc[IAB+1:2]];
    if (ins == HW) begin
      mhalt = 1'b1;
      mtag  = "R10";
      return;
    end
    op = ins[31:26]; fn = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; sh = ins[10:6];
    a = mreg[rs]; b = mreg[rt];
    se = {{16{ins[15]}}, ins[15:0]};
    ze = {16'h0, ins[15:0]};
    pc4 = mpc + 4;
    npc = pc4;
    addr = a + se;
    case (op)
      6'd0: case (fn)
        6'd32: wr(rd, a + b, "R2");
        6'd34: wr(rd, a - b, "R2");
        6'd36: wr(rd, a & b, "R2");
        6'd37: wr(rd, a | b, "R2");
        6'd39: wr(rd, ~(a | b), "R5");
        6'd42: wr(rd, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0, "R4");
        6'd0:  wr(rd, b << sh, "R5");
        6'd2:  wr(rd, b >> sh, "R5");
        6'd8:  begin npc = a; mtag = "R9"; end
        default: ;
      endcase
      6'd8:  wr(rt, a + se, "R3");
      6'd10: wr(rt, ($signed(a) < $signed(se)) ? 32'd1 : 32'd0, "R4");
      6'd12: wr(rt, a & ze, "R3");
      6'd13: wr(rt, a | ze, "R3");
      6'd35: wr(rt, mdm[addr[DAB+1:2]], "R6");
      6'd43: begin mdm[addr[DAB+1:2]] = b; mtag = "R6"; end
      6'd4:  begin if (a == b) npc = pc4 + (se << 2); mtag = "R7"; end
      6'd5:  begin if (a != b) npc = pc4 + (se << 2); mtag = "R7"; end
      6'd2:  begin npc = {pc4[31:28], ins[25:0], 2'b00}; mtag = "R8"; end
      6'd3:  begin npc = {pc4[31:28], ins[25:0], 2'b00}; wr(31, pc4, "R8"); end
      default: ;
    endcase
    mpc = npc;
  endtask

  task automatic load_all(input logic [31:0] dm1);
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = IAB'(i); imem_wdata = prog[i];
      mim[i] = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    dmem_we = 1'b1; dmem_addr = DAB'(1); dmem_wdata = dm1;
    for (int i = 0; i < DW; i++) mdm[i] = 32'h0;
    mdm[1] = dm1;
    @(negedge clk);
    dmem_we = 1'b0;
  endtask

  task automatic run_prog(input int max_cycles);
    int post;
    post = 0;
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    mpc = 32'h0; mhalt = 1'b0;
    // R11: registers cleared and halt low while reset is held
    for (int i = 0; i < 32; i++) begin
      dbg_sel = 5'(i);
      #0.1;
      chk("R11", $sformatf("reset value r%0d", i), dbg_data, 32'h0);
    end
    chk("R11", "halt in reset", {31'h0, halt}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    dbg_sel = 5'd1;
    #0.1;
    chk("R11", "no retire before third edge", dbg_data, 32'h0);
    for (int cyc = 0; cyc < max_cycles; cyc++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      dbg_sel = (mlast >= 0) ? 5'(mlast) : 5'(cyc % 32);
      #0.1;
      chk(mtag, $sformatf("r%0d after step %0d", dbg_sel, cyc),
          dbg_data, mreg[dbg_sel]);
      chk("R10", $sformatf("halt flag at step %0d", cyc),
          {31'h0, halt}, {31'h0, mhalt});
      if (mhalt) post++;
      if (post == 4) break;
    end
    // R13: full register sweep against the reference
    for (int i = 0; i < 32; i++) begin
      dbg_sel = 5'(i);
      #0.1;
      chk("R13", $sformatf("final r%0d", i), dbg_data, mreg[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // program A
    for (int i = 0; i < IW; i++) prog[i] = HW;
    prog[0]  = enc_i(6'd8, 0, 1, 5);                 // addi r1=5
    prog[1]  = enc_i(6'd8, 0, 2, -3);                // addi r2=-3
    prog[2]  = enc_r(6'd32, 1, 2, 3, 0);             // add
    prog[3]  = enc_r(6'd34, 2, 1, 4, 0);             // sub
    prog[4]  = enc_i(6'd13, 0, 5, 32'hF0F0);         // ori zero-extended
    prog[5]  = enc_i(6'd12, 2, 6, 32'hFFFF);         // andi zero-extended
    prog[6]  = enc_r(6'd36, 5, 6, 7, 0);             // and
    prog[7]  = enc_r(6'd37, 5, 2, 8, 0);             // or
    prog[8]  = enc_r(6'd39, 5, 0, 9, 0);             // nor
    prog[9]  = enc_r(6'd0, 0, 9, 10, 4);             // sll
    prog[10] = enc_r(6'd2, 0, 9, 11, 28);            // srl
    prog[11] = enc_r(6'd42, 2, 1, 12, 0);            // slt -> 1
    prog[12] = enc_r(6'd42, 1, 2, 13, 0);            // slt -> 0
    prog[13] = enc_i(6'd10, 2, 14, -2);              // slti -> 1
    prog[14] = enc_i(6'd10, 1, 15, -2);              // slti -> 0
    prog[15] = enc_i(6'd8, 0, 0, 7);                 // write to r0 ignored
    prog[16] = enc_r(6'd39, 0, 0, 16, 0);            // r16 = all ones
    prog[17] = enc_r(6'd2, 0, 16, 17, 1);            // r17 = 0x7fffffff
    prog[18] = enc_r(6'd32, 17, 1, 18, 0);           // overflow wraps
    prog[19] = enc_i(6'd43, 0, 3, 8);                // sw r3 -> word 2
    prog[20] = enc_i(6'd8, 0, 19, 16);               // r19 = 16
    prog[21] = enc_i(6'd43, 19, 4, -4);              // sw r4 -> word 3
    prog[22] = enc_i(6'd35, 0, 20, 8);               // lw
    prog[23] = enc_i(6'd35, 0, 21, 12);              // lw
    prog[24] = enc_i(6'd35, 0, 22, 4);               // lw preloaded word
    prog[25] = enc_i(6'd4, 1, 2, 5);                 // beq not taken
    prog[26] = enc_i(6'd5, 1, 2, 1);                 // bne taken
    prog[27] = enc_i(6'd8, 0, 23, 99);               // skipped
    prog[28] = enc_i(6'd4, 3, 20, 1);                // beq taken
    prog[29] = enc_i(6'd8, 0, 23, 77);               // skipped
    prog[30] = enc_j(6'd3, 40);                      // jal
    prog[31] = enc_j(6'd2, 44);                      // j
    prog[40] = enc_i(6'd8, 0, 24, 1);
    prog[41] = enc_r(6'd8, 31, 0, 0, 0);             // jr r31
    prog[44] = enc_i(6'd8, 25, 25, 1);
    prog[45] = enc_i(6'd5, 25, 1, -2);               // backward loop
    // R2: the example encoding of add r8,r17,r18
    chk("R2", "add encoding", enc_r(6'd32, 17, 18, 8, 0), 32'h0232_4020);
    load_all(32'hCAFE_0001);
    run_prog(300);
    dbg_sel = 5'd18; #0.1; chk("R12", "add overflow wraps", dbg_data, 32'h8000_0004);
    dbg_sel = 5'd0;  #0.1; chk("R1", "r0 after write", dbg_data, 32'h0);
    dbg_sel = 5'd23; #0.1; chk("R7", "skipped by branches", dbg_data, 32'h0);
    dbg_sel = 5'd25; #0.1; chk("R7", "loop count", dbg_data, 32'd5);
    dbg_sel = 5'd31; #0.1; chk("R8", "link value", dbg_data, 32'd124);
    dbg_sel = 5'd24; #0.1; chk("R9", "subroutine ran once", dbg_data, 32'd1);
    dbg_sel = 5'd22; #0.1; chk("R6", "preloaded word", dbg_data, 32'hCAFE_0001);
    dbg_sel = 5'd21; #0.1; chk("R6", "stored then loaded", dbg_data, 32'hFFFF_FFF8);
    dbg_sel = 5'd6;  #0.1; chk("R3", "andi zero extension", dbg_data, 32'h0000_FFFD);
    dbg_sel = 5'd10; #0.1; chk("R5", "sll zero fill", dbg_data, 32'hFFF0_F0F0);
    dbg_sel = 5'd11; #0.1; chk("R5", "srl zero fill", dbg_data, 32'h0000_000F);
    dbg_sel = 5'd14; #0.1; chk("R4", "slti signed", dbg_data, 32'd1);
    dbg_sel = 5'd12; #0.1; chk("R4", "slt signed", dbg_data, 32'd1);

    // program B: halt word at address 0, after a reset
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < IW; i++) prog[i] = HW;
    prog[1] = enc_i(6'd8, 0, 1, 9);
    load_all(32'h0);
    run_prog(20);
    dbg_sel = 5'd1; #0.1; chk("R10", "no retire after halt", dbg_data, 32'h0);
    chk("R10", "halt held", {31'h0, halt}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule